// File: doc/BRIEF.md
# Filtered Received-Message Logger

This block records messages that arrive from a group of readout channels into a memory that a host reads through a 16-bit register port. Each incoming message has a 48-bit payload and an 8-bit channel number. A host-programmed filter decides whether a message is kept. The filter holds a compare pattern and a per-bit enable mask for the channel number.

Each kept message becomes a four-word record at the current write pointer. The payload goes into the first three words, most significant part first. The channel number goes into the fourth word. The pointer then moves on by one record and wraps to zero after the last slot, so the oldest records are overwritten.

The four words of a record are written on four consecutive clocks. A one-entry holding register absorbs one message that arrives while a record is still being written. The host can read any word at any time. No interlock is provided: a read of a record that is being written may return a mix of old and new data.

Top module: `chan_msg_logger`

## Requirements
- R1: A message with `msg_valid` high is kept only when, for every channel bit i whose mask bit (filter bit 8+i) is 1, channel bit i equals pattern bit i (filter bit i). When the mask is zero, every message is kept.
- R2: A kept message is stored as four words at the pointer address p. Word p holds payload[47:32], word p+1 holds payload[31:16], word p+2 holds payload[15:0], and word p+3 holds the channel number in bits 7:0 with bits 15:8 zero.
- R3: The write pointer is a word address that grows by 4 for every stored record. After the record in the last slot (word 4092) it wraps to 0, and new records then overwrite the oldest ones.
- R4: A kept message is taken in on the clock edge where `msg_valid` is high. Its four words are written on the next four edges, and the pointer takes its new value on the edge that writes the fourth word.
- R5: A kept message that arrives while a record is being written is held in a single holding register. Its record is written directly after the current one. A kept message that arrives while the holding register is already full is discarded.
- R6: A message that fails the filter changes neither the pointer nor any memory word.
- R7: Host map. Address 0x0000 reads the pointer, zero-extended. Address 0x0001 is the filter register and can be read and written. Addresses 0x1000 to 0x1FFF read memory words 0 to 4095. Every other address reads 0. A read returns its data one clock after the address is presented. Host writes to the pointer or to the memory have no effect.
- R8: Reset is synchronous and active low. It sets the pointer and the filter to 0. After reset, every memory word reads 0 until its record has been written completely again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| msg_valid | input | 1 | Message present this cycle |
| msg_payload | input | 48 | Message payload |
| msg_chan | input | 8 | Channel number of the message |
| host_addr | input | 16 | Host word address |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data, one cycle after the address |

## Verification
A wrong filter decision shows up about six clocks after the message: either the pointer advances when it should not, or it fails to advance when it should. A bad word sequencer or a bad pointer step leaves payload halves in the wrong slot or the channel number off by one word. The host sees this as soon as it reads the record. A fault in the holding register appears in a burst of three back-to-back messages, as a missing second record or a stored third one. A wrap fault appears only after 1024 records, when slot 0 fails to receive the newest message.

// File: rtl/rxlog_pkg.sv
// Package: shared widths and types for the received-message logger.
// Assumes a 16-bit host word and a payload of exactly three host words.
package rxlog_pkg;
    localparam int WORD_W = 16;
    localparam int CHAN_W = 8;
    localparam int PAY_W  = 3 * WORD_W;

    typedef struct packed {
        logic [PAY_W-1:0]  pay;
        logic [CHAN_W-1:0] chan;
    } rx_msg_t;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_PTR  = 2'd1,
        SEL_FILT = 2'd2,
        SEL_MEM  = 2'd3
    } rd_sel_e;
endpackage

// File: rtl/rxlog_match.sv
// Module: masked channel-number compare.
// Asserts hit when every enabled channel bit equals the pattern bit.
// Purely combinational; the caller qualifies the result with its valid strobe.
module rxlog_match #(
    parameter int CHAN_W = 8
) (
    input  logic [CHAN_W-1:0] chan,
    input  logic [CHAN_W-1:0] pattern,
    input  logic [CHAN_W-1:0] mask,
    output logic              hit
);
    logic [CHAN_W-1:0] diff;

    // Purpose: flag the mismatching bits, then ignore the ones that are not enabled.
    always_comb begin
        diff = (chan ^ pattern) & mask;
        hit  = (diff == '0);
    end
endmodule

// File: rtl/rxlog_writer.sv
// Module: record sequencer with a one-entry holding register.
// Takes in kept messages and writes each one as four consecutive words at the
// write pointer, then steps the pointer by one record (it wraps naturally).
// Assumes at most one message per cycle. A message arriving while both the
// record register and the holding register are full is dropped.
module rxlog_writer
    import rxlog_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  rx_msg_t           in_msg,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_waddr,
    output logic [WORD_W-1:0] mem_wdata,
    output logic [ADDR_W-1:0] wr_ptr,
    output logic              busy
);
    localparam logic [ADDR_W-1:0] REC_STEP = ADDR_W'(4);

    rx_msg_t           rec_q, skid_q;
    logic              busy_q, skid_v_q;
    logic [1:0]        phase_q;
    logic [ADDR_W-1:0] ptr_q;
    logic              last_word, free;

    // Purpose: pick the word for the current phase and form its address.
    always_comb begin
        last_word = busy_q && (phase_q == 2'd3);
        free      = !busy_q || last_word;
        mem_we    = busy_q;
        mem_waddr = ptr_q + {{(ADDR_W-2){1'b0}}, phase_q};
        case (phase_q)
            2'd0:    mem_wdata = rec_q.pay[PAY_W-1 -: WORD_W];
            2'd1:    mem_wdata = rec_q.pay[PAY_W-WORD_W-1 -: WORD_W];
            2'd2:    mem_wdata = rec_q.pay[WORD_W-1:0];
            default: mem_wdata = {{(WORD_W-CHAN_W){1'b0}}, rec_q.chan};
        endcase
    end

    // Purpose: advance the phase and the pointer, and move messages in and out of the holding register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q   <= 1'b0;
            skid_v_q <= 1'b0;
            phase_q  <= 2'd0;
            ptr_q    <= '0;
            rec_q    <= '0;
            skid_q   <= '0;
        end else begin
            if (busy_q)
                phase_q <= phase_q + 2'd1;
            if (last_word)
                ptr_q <= ptr_q + REC_STEP;
            if (free) begin
                if (skid_v_q) begin
                    rec_q    <= skid_q;
                    busy_q   <= 1'b1;
                    skid_v_q <= in_valid;
                    if (in_valid)
                        skid_q <= in_msg;
                end else if (in_valid) begin
                    rec_q  <= in_msg;
                    busy_q <= 1'b1;
                end else begin
                    busy_q <= 1'b0;
                end
            end else if (in_valid && !skid_v_q) begin
                skid_q   <= in_msg;
                skid_v_q <= 1'b1;
            end
        end
    end

    assign wr_ptr = ptr_q;
    assign busy   = busy_q;
endmodule

// File: rtl/rxlog_mem.sv
// Module: record memory with one write port and one registered read port.
// A validity bit per four-word record is cleared by reset and set when the
// record's last word is written. Words of a record whose bit is clear read 0,
// so the array itself needs no reset.
module rxlog_mem
    import rxlog_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [WORD_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int NREC  = DEPTH / 4;

    logic [WORD_W-1:0] mem_q [DEPTH];
    logic [NREC-1:0]   rec_valid_q;
    logic [WORD_W-1:0] rdata_q;

    // Purpose: store write data (no reset on the array).
    always_ff @(posedge clk) begin
        if (we)
            mem_q[waddr] <= wdata;
    end

    // Purpose: track completed records and register the read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rec_valid_q <= '0;
            rdata_q     <= '0;
        end else begin
            if (we && (waddr[1:0] == 2'b11))
                rec_valid_q[waddr[ADDR_W-1:2]] <= 1'b1;
            rdata_q <= rec_valid_q[raddr[ADDR_W-1:2]] ? mem_q[raddr] : '0;
        end
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/chan_msg_logger.sv
// Module: top level of the filtered received-message logger.
// Filters incoming messages on their channel number, writes the kept ones as
// four-word records and serves host reads of the pointer, filter and memory
// with one cycle of latency. Assumes a 16-bit host address space.
module chan_msg_logger
    import rxlog_pkg::*;
#(
    parameter int              ADDR_W    = 12,
    parameter logic [15:0]     PTR_ADDR  = 16'h0000,
    parameter logic [15:0]     FILT_ADDR = 16'h0001,
    parameter logic [15:0]     MEM_BASE  = 16'h1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              msg_valid,
    input  logic [PAY_W-1:0]  msg_payload,
    input  logic [CHAN_W-1:0] msg_chan,
    input  logic [15:0]       host_addr,
    input  logic              host_wr,
    input  logic [15:0]       host_wdata,
    output logic [15:0]       host_rdata
);
    localparam int          FILT_W  = 2 * CHAN_W;
    localparam logic [15:0] MEM_TAG = MEM_BASE >> ADDR_W;

    logic [FILT_W-1:0] filt_q;
    logic              chan_hit, msg_keep;
    rx_msg_t           in_msg;
    logic              mem_we, rec_busy;
    logic [ADDR_W-1:0] mem_waddr, wr_ptr;
    logic [WORD_W-1:0] mem_wdata, mem_rdata;
    rd_sel_e           rsel_d, rsel_q;
    logic [15:0]       reg_q;

    // Purpose: hold the host-programmed filter (mask in the upper half, pattern in the lower).
    always_ff @(posedge clk) begin
        if (!rst_n)
            filt_q <= '0;
        else if (host_wr && host_addr == FILT_ADDR)
            filt_q <= host_wdata[FILT_W-1:0];
    end

    rxlog_match #(.CHAN_W(CHAN_W)) u_match (
        .chan    (msg_chan),
        .pattern (filt_q[CHAN_W-1:0]),
        .mask    (filt_q[FILT_W-1:CHAN_W]),
        .hit     (chan_hit)
    );

    // Purpose: qualify the filter result and bundle the message.
    always_comb begin
        msg_keep    = msg_valid && chan_hit;
        in_msg.pay  = msg_payload;
        in_msg.chan = msg_chan;
    end

    rxlog_writer #(.ADDR_W(ADDR_W)) u_writer (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (msg_keep),
        .in_msg    (in_msg),
        .mem_we    (mem_we),
        .mem_waddr (mem_waddr),
        .mem_wdata (mem_wdata),
        .wr_ptr    (wr_ptr),
        .busy      (rec_busy)
    );

    rxlog_mem #(.ADDR_W(ADDR_W)) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (host_addr[ADDR_W-1:0]),
        .rdata (mem_rdata)
    );

    // Purpose: decode the host address into a read source.
    always_comb begin
        if ((host_addr >> ADDR_W) == MEM_TAG)
            rsel_d = SEL_MEM;
        else if (host_addr == PTR_ADDR)
            rsel_d = SEL_PTR;
        else if (host_addr == FILT_ADDR)
            rsel_d = SEL_FILT;
        else
            rsel_d = SEL_NONE;
    end

    // Purpose: register the read source and the register value so every read takes one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsel_q <= SEL_NONE;
            reg_q  <= '0;
        end else begin
            rsel_q <= rsel_d;
            case (rsel_d)
                SEL_PTR:  reg_q <= 16'(wr_ptr);
                SEL_FILT: reg_q <= 16'(filt_q);
                default:  reg_q <= '0;
            endcase
        end
    end

    assign host_rdata = (rsel_q == SEL_MEM) ? 16'(mem_rdata) : reg_q;
endmodule

// File: rtl/rxlog_checker.sv
// Module: assertion checker for chan_msg_logger, attached with bind below.
// Watches the write port, the pointer, the filter and the sequencer busy flag.
module rxlog_checker #(
    parameter int ADDR_W = 12,
    parameter int FILT_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              keep,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_waddr,
    input logic [ADDR_W-1:0] wr_ptr,
    input logic              rec_busy,
    input logic [FILT_W-1:0] filt
);
    // R3: the pointer always names the start of a record slot
    a_r3_ptr_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ptr[1:0] == 2'b00);

    // R3: the pointer moves only forward by one record
    a_r3_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(wr_ptr) |-> wr_ptr == $past(wr_ptr) + ADDR_W'(4));

    // R2, R4: words after the first follow the previous word on the next cycle
    a_r4_word_order: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && mem_waddr[1:0] != 2'b00) |->
            ($past(mem_we) && mem_waddr == $past(mem_waddr) + ADDR_W'(1)));

    // R2: a record starts at the pointer
    a_r2_start_at_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && mem_waddr[1:0] == 2'b00) |-> mem_waddr == wr_ptr);

    // R4: an idle sequencer takes a kept message on the same edge
    a_r4_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (keep && !rec_busy) |=> rec_busy);

    // R8: pointer and filter are zero when reset is released
    a_r8_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (wr_ptr == '0 && filt == '0));
endmodule

bind chan_msg_logger rxlog_checker #(.ADDR_W(ADDR_W), .FILT_W(FILT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .keep      (msg_keep),
    .mem_we    (mem_we),
    .mem_waddr (mem_waddr),
    .wr_ptr    (wr_ptr),
    .rec_busy  (rec_busy),
    .filt      (filt_q)
);

// File: tb/sim_chan_msg_logger.sv
`timescale 1ns/1ps
module sim_chan_msg_logger;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        msg_valid = 1'b0;
    logic [47:0] msg_payload = '0;
    logic [7:0]  msg_chan = '0;
    logic [15:0] host_addr = '0;
    logic        host_wr = 1'b0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    chan_msg_logger u0 (
        .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_payload(msg_payload),
        .msg_chan(msg_chan), .host_addr(host_addr), .host_wr(host_wr),
        .host_wdata(host_wdata), .host_rdata(host_rdata)
    );

    // filter value, channel, expected keep
    typedef struct packed { logic [15:0] filt; logic [7:0] chan; logic keep; } vec_t;
    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{16'h0000, 8'h05, 1'b1},
        '{16'hFF3C, 8'h3C, 1'b1},
        '{16'hFF3C, 8'h3D, 1'b0},
        '{16'h0F0A, 8'h7A, 1'b1},
        '{16'h0F0A, 8'h7B, 1'b0},
        '{16'h8080, 8'h80, 1'b1},
        '{16'h8080, 8'h7F, 1'b0},
        '{16'h0100, 8'h01, 1'b0},
        '{16'h0000, 8'hFF, 1'b1}
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic host_read(input logic [15:0] a, output logic [15:0] d);
        @(negedge clk);
        host_addr = a;
        host_wr = 1'b0;
        @(negedge clk);
        d = host_rdata;
    endtask

    task automatic host_write(input logic [15:0] a, input logic [15:0] d);
        @(negedge clk);
        host_addr = a;
        host_wdata = d;
        host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic send(input logic [7:0] ch, input logic [47:0] pl);
        @(negedge clk);
        msg_valid = 1'b1;
        msg_chan = ch;
        msg_payload = pl;
        @(negedge clk);
        msg_valid = 1'b0;
    endtask

    task automatic check_rec(input string req, input logic [15:0] p,
                             input logic [7:0] ch, input logic [47:0] pl);
        logic [15:0] d;
        host_read(16'h1000 + p, d);      chk(req, d, pl[47:32]);
        host_read(16'h1000 + p + 1, d);  chk(req, d, pl[31:16]);
        host_read(16'h1000 + p + 2, d);  chk(req, d, pl[15:0]);
        host_read(16'h1000 + p + 3, d);  chk(req, d, {8'h00, ch});
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin : main
        logic [15:0] d;
        logic [15:0] eptr;
        logic [47:0] pl;
        do_reset();

        // R8: reset state
        host_read(16'h0000, d); chk("R8 ptr", d, 16'h0000);
        host_read(16'h0001, d); chk("R8 filter", d, 16'h0000);
        host_read(16'h1000, d); chk("R8 mem first", d, 16'h0000);
        host_read(16'h1FFF, d); chk("R8 mem last", d, 16'h0000);

        // R1 R2 R6 R7: table walk
        eptr = 16'h0000;
        for (int i = 0; i < NV; i++) begin
            pl = {16'hA000 | 16'(i), 16'hB000 | 16'(i), 16'hC000 | 16'(i)};
            host_write(16'h0001, VECS[i].filt);
            host_read(16'h0001, d); chk("R7 filter readback", d, VECS[i].filt);
            send(VECS[i].chan, pl);
            repeat (6) @(negedge clk);
            if (VECS[i].keep) begin
                check_rec("R2 record", eptr, VECS[i].chan, pl);
                eptr = eptr + 16'd4;
                host_read(16'h0000, d); chk("R1 R3 kept ptr", d, eptr);
            end else begin
                host_read(16'h0000, d); chk("R1 R6 dropped ptr", d, eptr);
                host_read(16'h1000 + eptr, d); chk("R6 slot untouched", d, 16'h0000);
                host_read(16'h1000 + eptr + 3, d); chk("R6 slot untouched", d, 16'h0000);
            end
        end

        // R7: unmapped reads and ignored writes
        host_read(16'h0005, d); chk("R7 unmapped", d, 16'h0000);
        host_read(16'h3000, d); chk("R7 unmapped high", d, 16'h0000);
        host_write(16'h0000, 16'h0123);
        host_read(16'h0000, d); chk("R7 ptr write ignored", d, eptr);
        host_write(16'h1000, 16'h7777);
        host_read(16'h1000, d); chk("R7 mem write ignored", d, 16'hA000);

        // R4: pointer timing, host address held on the pointer
        host_write(16'h0001, 16'h0000);
        @(negedge clk);
        host_addr = 16'h0000;
        msg_valid = 1'b1; msg_chan = 8'h42; msg_payload = 48'h1111_2222_3333;
        @(negedge clk);
        msg_valid = 1'b0;
        for (int k = 1; k <= 5; k++) begin
            @(negedge clk);
            chk("R4 ptr timing", host_rdata, (k < 5) ? eptr : eptr + 16'd4);
        end
        check_rec("R4 record", eptr, 8'h42, 48'h1111_2222_3333);
        eptr = eptr + 16'd4;

        // R5: three kept messages back to back
        @(negedge clk);
        msg_valid = 1'b1; msg_chan = 8'h11; msg_payload = 48'h0A0A_0B0B_0C0C;
        @(negedge clk);
        msg_chan = 8'h22; msg_payload = 48'h1A1A_1B1B_1C1C;
        @(negedge clk);
        msg_chan = 8'h33; msg_payload = 48'h2A2A_2B2B_2C2C;
        @(negedge clk);
        msg_valid = 1'b0;
        repeat (12) @(negedge clk);
        check_rec("R5 first", eptr, 8'h11, 48'h0A0A_0B0B_0C0C);
        check_rec("R5 held", eptr + 16'd4, 8'h22, 48'h1A1A_1B1B_1C1C);
        host_read(16'h0000, d); chk("R5 ptr after burst", d, eptr + 16'd8);
        host_read(16'h1000 + eptr + 16'd8, d); chk("R5 third dropped", d, 16'h0000);
        host_read(16'h1000 + eptr + 16'd11, d); chk("R5 third dropped", d, 16'h0000);

        // R8: reset clears the stored records and the filter
        host_write(16'h0001, 16'hFFFF);
        do_reset();
        host_read(16'h1000, d); chk("R8 mem after reset", d, 16'h0000);
        host_read(16'h0000, d); chk("R8 ptr after reset", d, 16'h0000);
        host_read(16'h0001, d); chk("R8 filter after reset", d, 16'h0000);

        // R3: wrap after 1024 records
        for (int i = 0; i < 1024; i++) begin
            send(8'(i), {16'h5A00, 16'(i), 16'(~i)});
            repeat (3) @(negedge clk);
        end
        repeat (3) @(negedge clk);
        host_read(16'h0000, d); chk("R3 wrap to zero", d, 16'h0000);
        check_rec("R3 last slot", 16'd4092, 8'hFF, {16'h5A00, 16'd1023, 16'(~1023)});
        send(8'hC3, 48'hDEAD_BEEF_CAFE);
        repeat (6) @(negedge clk);
        host_read(16'h0000, d); chk("R3 after wrap", d, 16'h0004);
        check_rec("R3 overwrite", 16'd0, 8'hC3, 48'hDEAD_BEEF_CAFE);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule